// File: doc/BRIEF.md
# Register Renamer with Map Table and Free List

This block renames one instruction per cycle. Each logical register operand is translated into a tag for a physical register file that has more entries than the architectural one. A speculative map table holds the current physical tag for each logical register. A circular free list hands out unused physical tags. For each instruction the block returns the physical tags of its two sources. If the instruction writes a register, it also returns a newly allocated physical destination and the mapping that destination replaced. That replaced tag travels with the instruction down the pipeline.

When the instruction retires, the pipeline presents its logical destination, its new tag and its replaced tag on the commit port. The replaced tag goes back on the tail of the free list, and a committed copy of the map table is updated. A flush restores the speculative map table and the free-list read pointer from the committed state in one cycle. This discards every renaming that has not yet retired. When no free tag is left, an instruction that needs a destination is held off by a stall output, and no mapping changes.

Top module: `reg_renamer`

## Requirements
- R1: After reset, logical register i maps to physical register i. The free list holds tags NUM_LOG through NUM_PHYS-1, with NUM_LOG at its head.
- R2: For a valid rename, ren_src1_pd_o and ren_src2_pd_o equal the current speculative mapping of ren_src1_i and ren_src2_i. These outputs are combinational in the same cycle.
- R3: A source naming the same logical register as the destination of the same instruction gets the mapping from before this instruction.
- R4: A rename that allocates (valid, has destination, list not empty, no flush) takes ren_dst_pd_o from the free-list head. The map entry of ren_dst_i holds that tag from the next cycle on.
- R5: ren_old_pd_o equals the mapping of ren_dst_i just before the allocation.
- R6: A newly allocated tag is not the current mapping of any logical register.
- R7: A commit appends cmt_old_pd_i to the tail of the free list. Tags are handed out in the order they entered the list.
- R8: stall_o is 1 exactly when ren_valid_i and ren_has_dst_i are 1 and the free list is empty. A stalled rename changes no mapping and consumes no tag.
- R9: A rename with ren_valid_i low, or with ren_has_dst_i low, changes neither the map table nor the free list.
- R10: When flush_i is high, the speculative map and the free-list state are replaced by the committed state at the next edge. All NUM_PHYS-NUM_LOG unmapped tags become free again, and a rename in that cycle is ignored.
- R11: A commit sets the committed mapping of cmt_dst_i to cmt_pd_i, so a later flush restores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Restore speculative state from committed state |
| ren_valid_i | input | 1 | Rename request valid |
| ren_has_dst_i | input | 1 | Instruction writes a register |
| ren_src1_i | input | $clog2(NUM_LOG) | Logical source 1 |
| ren_src2_i | input | $clog2(NUM_LOG) | Logical source 2 |
| ren_dst_i | input | $clog2(NUM_LOG) | Logical destination |
| stall_o | output | 1 | Rename held off: no free tag |
| ren_src1_pd_o | output | $clog2(NUM_PHYS) | Physical tag of source 1 |
| ren_src2_pd_o | output | $clog2(NUM_PHYS) | Physical tag of source 2 |
| ren_dst_pd_o | output | $clog2(NUM_PHYS) | Newly allocated destination tag |
| ren_old_pd_o | output | $clog2(NUM_PHYS) | Replaced mapping of the destination |
| cmt_valid_i | input | 1 | A register-writing instruction retires |
| cmt_dst_i | input | $clog2(NUM_LOG) | Logical destination of the retiring instruction |
| cmt_pd_i | input | $clog2(NUM_PHYS) | Tag that instruction was given |
| cmt_old_pd_i | input | $clog2(NUM_PHYS) | Replaced tag to release |

## Verification
The assertions assume that commits arrive in program order and carry exactly the tags the renamer issued. They also assume that a commit never shares a cycle with a flush, and that no more tags are released than are in flight. Under these assumptions the free-list count can never exceed its depth. The bench keeps to these rules by driving the commit port only from its own queue of in-flight renames, always taking the oldest first. It never asserts a commit in a flush cycle, and it empties that queue on every flush.

// File: rtl/renamer_pkg.sv
`timescale 1ns/1ps
package renamer_pkg;
  localparam int unsigned DEF_NUM_LOG  = 8;
  localparam int unsigned DEF_NUM_PHYS = 16;
endpackage

// File: rtl/rn_map_table.sv
`timescale 1ns/1ps
module rn_map_table #(
  parameter int unsigned NUM_LOG  = 8,
  parameter int unsigned NUM_PHYS = 16,
  localparam int unsigned LW = $clog2(NUM_LOG),
  localparam int unsigned PW = $clog2(NUM_PHYS),
  localparam int unsigned NRD = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic [LW-1:0] rd_idx_i [NRD],
  output logic [PW-1:0] rd_pd_o  [NRD],
  input  logic          wr_en_i,
  input  logic [LW-1:0] wr_idx_i,
  input  logic [PW-1:0] wr_pd_i,
  input  logic          cmt_en_i,
  input  logic [LW-1:0] cmt_idx_i,
  input  logic [PW-1:0] cmt_pd_i
);
  logic [PW-1:0] spec_q [NUM_LOG];
  logic [PW-1:0] arch_q [NUM_LOG];

  // reads see state before this cycle's write
  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_pd_o[r] = spec_q[rd_idx_i[r]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_LOG; i++) spec_q[i] <= PW'(i);
    end else if (flush_i) begin
      for (int i = 0; i < NUM_LOG; i++) spec_q[i] <= arch_q[i];
    end else if (wr_en_i) begin
      spec_q[wr_idx_i] <= wr_pd_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_LOG; i++) arch_q[i] <= PW'(i);
    end else if (cmt_en_i) begin
      arch_q[cmt_idx_i] <= cmt_pd_i;
    end
  end
endmodule

// File: rtl/rn_free_list.sv
`timescale 1ns/1ps
module rn_free_list #(
  parameter int unsigned NUM_LOG  = 8,
  parameter int unsigned NUM_PHYS = 16,
  localparam int unsigned PW    = $clog2(NUM_PHYS),
  localparam int unsigned DEPTH = NUM_PHYS - NUM_LOG,
  localparam int unsigned FW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          pop_i,
  input  logic          push_i,
  input  logic [PW-1:0] push_pd_i,
  output logic [PW-1:0] head_pd_o,
  output logic          empty_o,
  output logic [CW-1:0] cnt_o
);
  logic [PW-1:0] slot_q [DEPTH];
  logic [FW-1:0] head_q, tail_q, arch_head_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [FW-1:0] nxt(input logic [FW-1:0] p);
    return (p == FW'(DEPTH - 1)) ? '0 : p + FW'(1);
  endfunction

  assign head_pd_o = slot_q[head_q];
  assign empty_o   = (cnt_q == '0);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) slot_q[k] <= PW'(NUM_LOG + k);
    end else if (push_i) begin
      slot_q[tail_q] <= push_pd_i;
    end
  end

  // each commit retires one allocation in order: committed head steps once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q      <= '0;
      tail_q      <= '0;
      arch_head_q <= '0;
      cnt_q       <= CW'(DEPTH);
    end else begin
      if (push_i) begin
        tail_q      <= nxt(tail_q);
        arch_head_q <= nxt(arch_head_q);
      end
      if (flush_i) begin
        head_q <= arch_head_q;
        cnt_q  <= CW'(DEPTH);
      end else begin
        if (pop_i) head_q <= nxt(head_q);
        cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
      end
    end
  end
endmodule

// File: rtl/reg_renamer.sv
`timescale 1ns/1ps
module reg_renamer
  import renamer_pkg::*;
#(
  parameter int unsigned NUM_LOG  = DEF_NUM_LOG,
  parameter int unsigned NUM_PHYS = DEF_NUM_PHYS,
  localparam int unsigned LW = $clog2(NUM_LOG),
  localparam int unsigned PW = $clog2(NUM_PHYS),
  localparam int unsigned CW = $clog2(NUM_PHYS - NUM_LOG + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          ren_valid_i,
  input  logic          ren_has_dst_i,
  input  logic [LW-1:0] ren_src1_i,
  input  logic [LW-1:0] ren_src2_i,
  input  logic [LW-1:0] ren_dst_i,
  output logic          stall_o,
  output logic [PW-1:0] ren_src1_pd_o,
  output logic [PW-1:0] ren_src2_pd_o,
  output logic [PW-1:0] ren_dst_pd_o,
  output logic [PW-1:0] ren_old_pd_o,
  input  logic          cmt_valid_i,
  input  logic [LW-1:0] cmt_dst_i,
  input  logic [PW-1:0] cmt_pd_i,
  input  logic [PW-1:0] cmt_old_pd_i
);
  logic          fl_empty;
  logic [PW-1:0] fl_head_pd;
  logic [CW-1:0] fl_cnt;
  logic          alloc;
  logic [LW-1:0] rd_idx [3];
  logic [PW-1:0] rd_pd  [3];

  assign stall_o = ren_valid_i & ren_has_dst_i & fl_empty;
  assign alloc   = ren_valid_i & ren_has_dst_i & ~fl_empty & ~flush_i;

  assign rd_idx[0] = ren_src1_i;
  assign rd_idx[1] = ren_src2_i;
  assign rd_idx[2] = ren_dst_i;

  assign ren_src1_pd_o = rd_pd[0];
  assign ren_src2_pd_o = rd_pd[1];
  assign ren_old_pd_o  = rd_pd[2];
  assign ren_dst_pd_o  = fl_head_pd;

  rn_map_table #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS)) i_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush_i),
    .rd_idx_i  (rd_idx),
    .rd_pd_o   (rd_pd),
    .wr_en_i   (alloc),
    .wr_idx_i  (ren_dst_i),
    .wr_pd_i   (fl_head_pd),
    .cmt_en_i  (cmt_valid_i),
    .cmt_idx_i (cmt_dst_i),
    .cmt_pd_i  (cmt_pd_i)
  );

  rn_free_list #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS)) i_fl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush_i),
    .pop_i     (alloc),
    .push_i    (cmt_valid_i),
    .push_pd_i (cmt_old_pd_i),
    .head_pd_o (fl_head_pd),
    .empty_o   (fl_empty),
    .cnt_o     (fl_cnt)
  );
endmodule

// File: rtl/rn_checker.sv
`timescale 1ns/1ps
module rn_checker #(
  parameter int unsigned NUM_LOG  = 8,
  parameter int unsigned NUM_PHYS = 16,
  localparam int unsigned PW = $clog2(NUM_PHYS),
  localparam int unsigned CW = $clog2(NUM_PHYS - NUM_LOG + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          flush_i,
  input logic          alloc_i,
  input logic          cmt_valid_i,
  input logic          stall_i,
  input logic [CW-1:0] cnt_i,
  input logic [PW-1:0] dst_pd_i,
  input logic [PW-1:0] old_pd_i
);
  localparam logic [CW-1:0] FULL = CW'(NUM_PHYS - NUM_LOG);

  assert_cnt_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= FULL);

  assert_stall_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> (cnt_i == '0));

  assert_stall_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && !cmt_valid_i && !flush_i) |=> $stable(cnt_i));

  assert_alloc_pop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && !cmt_valid_i) |=> (cnt_i == $past(cnt_i) - CW'(1)));

  assert_new_differs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> (dst_pd_i != old_pd_i));

  assert_flush_refill_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cnt_i == FULL));

  assert_no_cmt_on_flush_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flush_i && cmt_valid_i));
endmodule

bind reg_renamer rn_checker #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS)) i_rn_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .flush_i     (flush_i),
  .alloc_i     (alloc),
  .cmt_valid_i (cmt_valid_i),
  .stall_i     (stall_o),
  .cnt_i       (fl_cnt),
  .dst_pd_i    (ren_dst_pd_o),
  .old_pd_i    (ren_old_pd_o)
);

// File: tb/test_reg_renamer.sv
`timescale 1ns/1ps
module test_reg_renamer;
  localparam int NL = 8;
  localparam int NP = 16;
  localparam int LW = $clog2(NL);
  localparam int PW = $clog2(NP);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic flush_i = 1'b0, ren_valid_i = 1'b0, ren_has_dst_i = 1'b0;
  logic [LW-1:0] ren_src1_i = '0, ren_src2_i = '0, ren_dst_i = '0;
  logic stall_o;
  logic [PW-1:0] ren_src1_pd_o, ren_src2_pd_o, ren_dst_pd_o, ren_old_pd_o;
  logic cmt_valid_i = 1'b0;
  logic [LW-1:0] cmt_dst_i = '0;
  logic [PW-1:0] cmt_pd_i = '0, cmt_old_pd_i = '0;

  int checks = 0;
  int errors = 0;

  int sm [NL];
  int cm [NL];
  int sf [$];
  int cf [$];
  int if_ld [$];
  int if_pd [$];
  int if_old [$];

  always #2.5 clk_i = ~clk_i;

  reg_renamer #(.NUM_LOG(NL), .NUM_PHYS(NP)) i_reg_renamer (
    .clk_i, .rst_ni, .flush_i, .ren_valid_i, .ren_has_dst_i,
    .ren_src1_i, .ren_src2_i, .ren_dst_i, .stall_o,
    .ren_src1_pd_o, .ren_src2_pd_o, .ren_dst_pd_o, .ren_old_pd_o,
    .cmt_valid_i, .cmt_dst_i, .cmt_pd_i, .cmt_old_pd_i
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NL; i++) begin sm[i] = i; cm[i] = i; end
    sf.delete(); cf.delete();
    for (int k = NL; k < NP; k++) begin sf.push_back(k); cf.push_back(k); end
    if_ld.delete(); if_pd.delete(); if_old.delete();
  endtask

  task automatic step(bit fl, bit rv, bit hd, int s1, int s2, int d, bit cv);
    bit do_cmt, exp_stall, do_alloc;
    int p, hits;
    @(negedge clk_i);
    do_cmt = cv && !fl && (if_ld.size() > 0);
    flush_i = fl; ren_valid_i = rv; ren_has_dst_i = hd;
    ren_src1_i = LW'(s1); ren_src2_i = LW'(s2); ren_dst_i = LW'(d);
    cmt_valid_i = do_cmt;
    if (do_cmt) begin
      cmt_dst_i = LW'(if_ld[0]); cmt_pd_i = PW'(if_pd[0]); cmt_old_pd_i = PW'(if_old[0]);
    end
    #1;
    exp_stall = rv && hd && (sf.size() == 0);
    chk("R8 stall", stall_o, exp_stall);
    do_alloc = rv && hd && !exp_stall && !fl;
    if (rv && !fl) begin
      chk((hd && s1 == d) ? "R3 src1 old map" : "R2 src1", ren_src1_pd_o, sm[s1]);
      chk((hd && s2 == d) ? "R3 src2 old map" : "R2 src2", ren_src2_pd_o, sm[s2]);
    end
    if (do_alloc) begin
      chk("R4 dst from head", ren_dst_pd_o, sf[0]);
      chk("R5 old mapping", ren_old_pd_o, sm[d]);
      hits = 0;
      for (int k = 0; k < NL; k++) if (sm[k] == int'(ren_dst_pd_o)) hits++;
      chk("R6 new tag unmapped", hits, 0);
    end
    if (fl) begin
      // R10: speculative state replaced by committed state
      sm = cm; sf = cf;
      if_ld.delete(); if_pd.delete(); if_old.delete();
    end else begin
      if (do_alloc) begin
        p = sf.pop_front();
        if_ld.push_back(d); if_pd.push_back(p); if_old.push_back(sm[d]);
        sm[d] = p;
      end
      if (do_cmt) begin
        // R11 committed map, R7 release at tail
        cm[if_ld[0]] = if_pd[0];
        void'(cf.pop_front());
        cf.push_back(if_old[0]);
        sf.push_back(if_old[0]);
        void'(if_ld.pop_front()); void'(if_pd.pop_front()); void'(if_old.pop_front());
      end
    end
  endtask

  task automatic idle();
    @(negedge clk_i);
    flush_i = 0; ren_valid_i = 0; ren_has_dst_i = 0; cmt_valid_i = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1729));
    model_reset();
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 reset stall low", stall_o, 0);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1: identity mapping visible through the sources
    for (int i = 0; i < NL; i++) begin
      step(0, 1, 0, i, NL - 1 - i, 0, 0);
      chk("R1 identity map", ren_src1_pd_o, i);
    end
    // R1: first allocation takes tag NUM_LOG
    step(0, 1, 1, 3, 3, 3, 0);
    chk("R1 first free tag", ren_dst_pd_o, NL);
    // R3: reads after write see the new tag
    step(0, 1, 1, 3, 2, 2, 0);
    // R9: invalid and no-destination requests leave state alone
    step(0, 0, 1, 1, 1, 1, 0);
    step(0, 1, 0, 1, 2, 1, 0);
    step(0, 1, 0, 2, 3, 0, 0);
    // drain the list to force stalls (R8)
    for (int i = 0; i < NP; i++) step(0, 1, 1, i % NL, (i + 1) % NL, (i * 3) % NL, 0);
    step(0, 1, 1, 0, 1, 2, 0);
    step(0, 1, 0, 0, 2, 5, 0);
    // commit two, then rename to reuse released tags (R7)
    step(0, 0, 0, 0, 0, 0, 1);
    step(0, 1, 1, 4, 5, 6, 1);
    step(0, 1, 1, 6, 7, 1, 0);
    step(0, 1, 1, 6, 7, 1, 0);
    // flush restores committed map (R10, R11)
    step(1, 1, 1, 0, 0, 0, 0);
    for (int i = 0; i < NL; i++) step(0, 1, 0, i, i, 0, 0);

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      bit fl;
      fl = (($urandom % 64) == 0);
      step(fl, ($urandom % 10) < 8, ($urandom % 10) < 7,
           int'($urandom % NL), int'($urandom % NL), int'($urandom % NL),
           ($urandom % 10) < 4);
    end

    // back-to-back flush then full refill check (R10)
    step(1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < NP - NL; i++) step(0, 1, 1, i % NL, 0, i % NL, 0);
    step(0, 1, 1, 0, 0, 0, 0);
    chk("R10 refilled list drained", stall_o, 1);
    idle();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule